// File: doc/BRIEF.md
# LCD Line Timing Generator

This block turns the system clock into the row timing that a dot-matrix LCD common driver and its segment drivers share. A power-of-two prescaler makes a base tick. A dot counter counts one line's worth of dots, which is the dots per byte times the bytes per line. A line counter then walks the common rows of one frame. For every line the block emits a one-cycle shift strobe (`cl2_o`). At each frame boundary it emits a frame-start strobe and flips the drive-polarity signal `m_o`, which keeps the panel free of DC bias.

Software-visible fields arrive as plain inputs: a run bit, a 3-bit prescale select, a dot-pitch code, a byte-count code and a line-count code. When the run bit is low, the timing rests while the rest of the chip keeps working. The standby input freezes every register in place. Out-of-range pitch, byte-count and line-count codes are mapped onto legal values, so no code word can produce a degenerate line or frame.

Top module: `lcd_line_timer`

## Requirements
- R1: After reset `cl2_o`, `frame_o` and `m_o` are 0 and `line_o` is 0.
- R2: With prescale select k (0..7) on `div_sel_i`, one base tick occurs every 2^k clocks. A line therefore lasts 2^k × Dp × Dn clocks.
- R3: Dots per byte Dp is `pitch_i`+1 when `pitch_i` is 5, 6 or 7 (6, 7 or 8 dots). Every other `pitch_i` code gives 8 dots.
- R4: Bytes per line Dn is `bytes_i`+1, clamped to the range 2..10.
- R5: Lines per frame Nx is `lines_i`+1, clamped to the range 2..65. `line_o` runs 0,1,..,Nx−1 and then returns to 0, and it never exceeds 64.
- R6: `cl2_o` is a one-cycle high pulse once per line. It rises on the same clock edge on which `line_o` advances.
- R7: When `line_o` wraps from Nx−1 to 0, `frame_o` is high for that one cycle together with `cl2_o`, and `m_o` toggles. `m_o` changes at no other time.
- R8: While `run_i` is 0 (and standby is low), `cl2_o` and `frame_o` are 0 and `line_o` is 0, and `m_o` keeps its value. After `run_i` rises, the first `cl2_o` comes one full line period later.
- R9: While `standby_i` is 1, all outputs and all internal counts hold. Timing resumes where it stopped, so the line in progress is stretched by exactly the number of standby cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Display timing enable |
| div_sel_i | input | 3 | Prescale select, divide by 2^value |
| pitch_i | input | 3 | Dots-per-byte code (Dp−1) |
| bytes_i | input | 4 | Bytes-per-line code (Dn−1) |
| lines_i | input | 7 | Lines-per-frame code (Nx−1) |
| standby_i | input | 1 | Freeze all state and outputs |
| cl2_o | output | 1 | Line shift strobe |
| m_o | output | 1 | Frame polarity alternation |
| frame_o | output | 1 | Frame-start strobe |
| line_o | output | 7 | Index of the current line |

## Verification
The assertions assume that the five configuration fields change only while `run_i` is low. They also assume that standby is never raised while `cl2_o` is high. If standby caught the strobe high, the strobe would be held, and the one-cycle pulse check would not apply. The stimulus follows both rules. It stops the timing before it loads each new configuration. It raises standby only several cycles after an observed strobe, when the line in progress still has many cycles to run.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  localparam int unsigned DP_MAX = 8;
  localparam int unsigned DN_MIN = 2;
  localparam int unsigned DN_MAX = 10;
  localparam int unsigned NX_MIN = 2;
  localparam int unsigned NX_MAX = 65;

  // Dots per byte: codes 5..7 are legal, everything else maps to 8.
  function automatic int unsigned dots_per_byte(input int unsigned code);
    if (code >= 5 && code <= 7) return code + 1;
    return DP_MAX;
  endfunction

  // Bytes per line, clamped to 2..10.
  function automatic int unsigned bytes_per_line(input int unsigned code);
    int unsigned n;
    n = code + 1;
    if (n < DN_MIN) return DN_MIN;
    if (n > DN_MAX) return DN_MAX;
    return n;
  endfunction

  // Lines per frame, clamped to 2..65.
  function automatic int unsigned lines_per_frame(input int unsigned code);
    int unsigned n;
    n = code + 1;
    if (n < NX_MIN) return NX_MIN;
    if (n > NX_MAX) return NX_MAX;
    return n;
  endfunction

  function automatic int unsigned dots_per_line(input int unsigned pitch_code,
                                                input int unsigned bytes_code);
    return dots_per_byte(pitch_code) * bytes_per_line(bytes_code);
  endfunction

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter int SEL_W = 3,
  parameter int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             freeze,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'((32'd1 << sel) - 32'd1);
  assign tick  = run && !freeze && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!freeze) begin
      if (!run)       cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PRE_REST: assert property (@(posedge clk) disable iff (!rst_n) (!run && !freeze) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/lcd_dot_counter.sv
module lcd_dot_counter #(
  parameter int DOT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             freeze,
  input  logic             tick,
  input  logic [DOT_W-1:0] line_len,
  output logic             line_end
);

  logic [DOT_W-1:0] dot_q;

  assign line_end = tick && (dot_q == line_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dot_q <= '0;
    else if (!freeze) begin
      if (!run)          dot_q <= '0;
      else if (line_end) dot_q <= '0;
      else if (tick)     dot_q <= dot_q + 1'b1;
    end
  end

  AST_DOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) freeze |=> $stable(dot_q)); // R9

endmodule

// File: rtl/lcd_line_counter.sv
module lcd_line_counter #(
  parameter int LINE_W = 7,
  parameter int NX_TOP = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              freeze,
  input  logic              line_end,
  input  logic [LINE_W-1:0] nx,
  output logic              cl2,
  output logic              frame,
  output logic              m,
  output logic [LINE_W-1:0] line
);

  logic [LINE_W-1:0] line_q;
  logic              cl2_q, frame_q, m_q;
  logic              wrap;

  assign wrap = (line_q >= nx - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      cl2_q   <= 1'b0;
      frame_q <= 1'b0;
      m_q     <= 1'b0;
    end else if (!freeze) begin
      cl2_q   <= line_end;
      frame_q <= line_end && wrap;
      if (!run) begin
        line_q <= '0;
      end else if (line_end) begin
        line_q <= wrap ? '0 : line_q + 1'b1;
        if (wrap) m_q <= ~m_q;
      end
    end
  end

  assign cl2   = cl2_q;
  assign frame = frame_q;
  assign m     = m_q;
  assign line  = line_q;

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) line_q < LINE_W'(NX_TOP)); // R5

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int SEL_W   = 3,
  parameter int PITCH_W = 3,
  parameter int BYTES_W = 4,
  parameter int LINES_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic [SEL_W-1:0]     div_sel_i,
  input  logic [PITCH_W-1:0]   pitch_i,
  input  logic [BYTES_W-1:0]   bytes_i,
  input  logic [LINES_W-1:0]   lines_i,
  input  logic                 standby_i,
  output logic                 cl2_o,
  output logic                 m_o,
  output logic                 frame_o,
  output logic [LINES_W-1:0]   line_o
);

  import lcd_tim_pkg::*;

  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam int DOT_W = $clog2(DP_MAX * DN_MAX + 1);

  logic             base_tick;
  logic             line_end;
  logic [DOT_W-1:0]   line_len;
  logic [LINES_W-1:0] nx;

  assign line_len = DOT_W'(dots_per_line(32'(pitch_i), 32'(bytes_i)));
  assign nx       = LINES_W'(lines_per_frame(32'(lines_i)));

  lcd_prescaler #(.SEL_W(SEL_W), .CNT_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_i),
    .freeze (standby_i),
    .sel    (div_sel_i),
    .tick   (base_tick)
  );

  lcd_dot_counter #(.DOT_W(DOT_W)) u_dot (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .freeze   (standby_i),
    .tick     (base_tick),
    .line_len (line_len),
    .line_end (line_end)
  );

  lcd_line_counter #(.LINE_W(LINES_W), .NX_TOP(NX_MAX)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .freeze   (standby_i),
    .line_end (line_end),
    .nx       (nx),
    .cl2      (cl2_o),
    .frame    (frame_o),
    .m        (m_o),
    .line     (line_o)
  );

  AST_CL2_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (cl2_o && !standby_i) |=> !cl2_o); // R6
  AST_FRAME_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) frame_o |-> (cl2_o && line_o == '0)); // R7
  AST_M_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (m_o != $past(m_o)) |-> frame_o); // R7
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!run_i && !standby_i) |=> (!cl2_o && !frame_o && line_o == '0)); // R8
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) standby_i |=> ($stable(cl2_o) && $stable(m_o) && $stable(frame_o) && $stable(line_o))); // R9

endmodule

// File: tb/lcd_line_timer_tb.sv
module lcd_line_timer_tb;

  typedef struct {
    int    gap;
    int    line;
    bit    m;
    bit    frame;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic [2:0] div_sel_i = '0;
  logic [2:0] pitch_i = 3'd7;
  logic [3:0] bytes_i = '0;
  logic [6:0] lines_i = '0;
  logic       standby_i = 1'b0;
  logic       cl2_o, m_o, frame_o;
  logic [6:0] line_o;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   last_evt = 0;
  bit   exp_m = 1'b0;
  bit   prev_cl2 = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  lcd_line_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .div_sel_i(div_sel_i),
    .pitch_i(pitch_i), .bytes_i(bytes_i), .lines_i(lines_i),
    .standby_i(standby_i), .cl2_o(cl2_o), .m_o(m_o), .frame_o(frame_o),
    .line_o(line_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Bench-side decoding of the configuration codes.
  function automatic int bench_dp(input int code);
    case (code)
      5: return 6;
      6: return 7;
      7: return 8;
      default: return 8;
    endcase
  endfunction

  function automatic int bench_lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Monitor: pops one expected item per observed strobe.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && cl2_o && !prev_cl2) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected strobe", 1, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(cyc - last_evt == it.gap, it.tag, "line period", cyc - last_evt, it.gap);
          check(int'(line_o) == it.line, it.tag, "line index", int'(line_o), it.line);
          check(m_o == it.m, "R7", "polarity", int'(m_o), int'(it.m));
          check(frame_o == it.frame, "R7", "frame strobe", int'(frame_o), int'(it.frame));
          last_evt = cyc;
        end
      end
      prev_cl2 = cl2_o;
    end
  end

  task automatic run_case(input int sel, input int pitch, input int nbytes,
                          input int nlines_code, input int pulses,
                          input int stby, input string tag);
    int dp, dn, nx, period;
    @(negedge clk); #1;
    run_i = 1'b0;
    div_sel_i = 3'(sel);
    pitch_i = 3'(pitch);
    bytes_i = 4'(nbytes);
    lines_i = 7'(nlines_code);
    repeat (2) @(negedge clk);
    dp = bench_dp(pitch);
    dn = bench_lim(nbytes + 1, 2, 10);
    nx = bench_lim(nlines_code + 1, 2, 65);
    period = (2 ** sel) * dp * dn;
    for (int k = 1; k <= pulses; k++) begin
      exp_t it;
      it.line = k % nx;
      it.frame = (it.line == 0);
      if (it.frame) exp_m = ~exp_m;
      it.m = exp_m;
      it.gap = period + ((k == 2) ? stby : 0);
      it.tag = (k == 1) ? {tag, "/R8"} : ((k == 2 && stby > 0) ? "R9" : tag);
      exp_q.push_back(it);
    end
    @(negedge clk); #1;
    run_i = 1'b1;
    last_evt = cyc;
    if (stby > 0) begin
      logic [6:0] s_line;
      logic       s_m, s_cl2, s_fr;
      while (exp_q.size() > pulses - 1) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
      standby_i = 1'b1;
      s_line = line_o; s_m = m_o; s_cl2 = cl2_o; s_fr = frame_o;
      for (int i = 0; i < stby; i++) begin
        @(negedge clk);
        check(line_o == s_line && m_o == s_m && cl2_o == s_cl2 && frame_o == s_fr,
              "R9", "frozen outputs", int'({cl2_o, frame_o, m_o, line_o}),
              int'({s_cl2, s_fr, s_m, s_line}));
      end
      #1;
      standby_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check(!cl2_o && !frame_o && !m_o && line_o == '0, "R1", "outputs in reset",
          int'({cl2_o, frame_o, m_o, line_o}), 0);
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cl2_o && !frame_o && !m_o && line_o == '0, "R1", "outputs after reset",
          int'({cl2_o, frame_o, m_o, line_o}), 0);

    run_case(0, 7, 1, 2, 7, 0, "R2/R5/R6");   // 8x2 dots, 3 lines, no division
    run_case(2, 5, 9, 3, 5, 0, "R2/R3/R4");   // 6x10 dots, /4, 4 lines
    run_case(7, 6, 1, 1, 2, 0, "R2/R3");      // 7x2 dots, /128, 2 lines
    run_case(1, 2, 0, 0, 5, 0, "R3/R4/R5");   // illegal pitch->8, Dn->2, Nx->2
    run_case(0, 7, 15, 127, 67, 0, "R4/R5");  // Dn clamp 10, Nx clamp 65
    run_case(1, 5, 1, 4, 3, 10, "R9");        // standby stretches line 2

    @(negedge clk); #1;
    run_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!cl2_o && !frame_o && line_o == '0 && m_o == exp_m, "R8", "stopped state",
            int'({cl2_o, frame_o, m_o, line_o}), int'({1'b0, 1'b0, exp_m, 7'd0}));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule